// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address for a single access, which may be a load, a store or an instruction fetch. It reads page-table entries one at a time through a request/response memory port and works from the root table down toward the leaf. It then checks the leaf against the effective privilege and the access type. When the accessed or dirty flag has to change, it writes the updated entry back. The result is a physical address, the read/write/execute permissions to cache for the page, and a status of success, page fault or access fault.

A request carries the scheme selector, the root page number, the current privilege, the supervisor-may-touch-user flag (SUM), the make-executable-readable flag (MXR) and the machine-mode override pair: a modify-privilege bit and the saved previous privilege. The walker accepts a request only while `req_ready` is high. It reports through a one-cycle `res_valid` pulse.

Top module: `ptw_walker`

## Requirements
- R1: With effective privilege machine (code 3) or scheme code 0 (bare), the result has status 0 (ok), the low PA_W address bits unchanged and all three permissions set, and no memory read is made.
- R2: A machine-mode load or store with the modify-privilege bit set is checked with the saved previous privilege (0 user, 1 supervisor); a fetch always uses the current privilege.
- R3: Scheme 1 walks two levels with 10-bit indices and 4-byte entries (`mem_word4` high). Schemes 8, 9 and 10 walk three, four and five levels with 9-bit indices and 8-byte entries. Each entry address is table base plus index times entry size, starting with the most significant index, and the page offset is 12 bits.
- R4: In schemes 8, 9 and 10, every address bit above the highest translated bit must equal that bit, or the status is 1 (page fault) with no memory read. Any scheme code other than 0, 1, 8, 9 or 10 also gives status 1.
- R5: Entry flag layout is V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, and the page number starts at bit 10. An entry with V clear faults. An entry with R, W and X clear points to the next table, and if it sits at the last level it faults.
- R6: A leaf with W set and R clear (W alone, or W with X) is reserved and faults.
- R7: A leaf with U set faults unless the privilege is user, or is supervisor with SUM set on a load or store. A leaf with U clear faults unless the privilege is supervisor.
- R8: A leaf above the last level whose page number has any nonzero bit below that level's span faults.
- R9: A load needs R, or X with MXR set. A store needs W. A fetch needs X. Access codes are 0 load, 1 store and 2 fetch.
- R10: A successful leaf gets A set, and also D on a store. If that changes the entry, it is written once to the entry's address before the result. Otherwise, and on every fault, nothing is written.
- R11: The physical page number is the leaf page number ORed with the virtual page-number bits below the leaf level, followed by the 12-bit offset.
- R12: On success the result grants R when R or (X and MXR) is set, W when W is set and the access is a store or D is already set, and X when X is set. A fault grants nothing.
- R13: A read error on the memory port ends the walk with status 2 (access fault), whatever data comes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when req_ready is high |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Machine-mode modify-privilege bit |
| req_mpp | input | 2 | Saved previous privilege used when req_mprv applies |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_mode | input | 4 | Scheme: 0 bare, 1 two-level, 8/9/10 three/four/five-level |
| req_root | input | PA_W-12 | Root table page number |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_addr | output | PA_W | Entry address for read and write-back |
| mem_word4 | output | 1 | Entry is 4 bytes wide (else 8) |
| mem_rd_valid | input | 1 | Read response |
| mem_rd_data | input | 64 | Read data |
| mem_rd_err | input | 1 | Read response carries an error |
| mem_wr_en | output | 1 | One-cycle entry write-back |
| mem_wr_data | output | 64 | Updated entry |
| res_valid | output | 1 | One-cycle result pulse |
| res_status | output | 2 | 0 ok, 1 page fault, 2 access fault |
| res_paddr | output | PA_W | Physical address |
| res_r | output | 1 | Read permission |
| res_w | output | 1 | Write permission |
| res_x | output | 1 | Execute permission |

## Verification
A read error and a word that would otherwise be a valid entry can arrive in the same response cycle. The bench provokes this by flagging an error on the address of a valid pointer entry while the memory still returns that entry's data, and it expects an access fault after exactly two reads. Machine-mode bypass and the high-bit address check are also evaluated in the same acceptance cycle: an out-of-range address in machine mode must pass straight through, while the same kind of address under supervisor must fault, and in both cases the bench requires that no memory read takes place.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_PAGE   = 2'd1,
        ST_ACCESS = 2'd2
    } stat_e;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_WB, S_DONE
    } walk_st_e;

    localparam logic [1:0] PRV_USR = 2'd0;
    localparam logic [1:0] PRV_SUP = 2'd1;
    localparam logic [1:0] PRV_MCH = 2'd3;

    localparam logic [3:0] MD_BARE = 4'd0;
    localparam logic [3:0] MD_L2   = 4'd1;
    localparam logic [3:0] MD_L3   = 4'd8;
    localparam logic [3:0] MD_L4   = 4'd9;
    localparam logic [3:0] MD_L5   = 4'd10;

    localparam int PG_OFS      = 12;
    localparam int PTE_PPN_LSB = 10;
    localparam int IDX_W_NARROW = 10;
    localparam int IDX_W_WIDE   = 9;

    typedef struct packed {
        logic d;
        logic a;
        logic g;
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } pte_flags_t;

    // number of table levels for a scheme; 0 means unsupported
    function automatic logic [2:0] depth_of(logic [3:0] m);
        case (m)
            MD_L2:   return 3'd2;
            MD_L3:   return 3'd3;
            MD_L4:   return 3'd4;
            MD_L5:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    // upper address bits must all copy the highest translated bit
    function automatic logic canon_ok(logic [63:0] va, logic [2:0] depth);
        int          top;
        logic [63:0] m;
        top = PG_OFS + IDX_W_WIDE * int'(depth) - 1;
        m   = {64{1'b1}} << top;
        return ((va & m) == 64'd0) || ((va & m) == m);
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic [63:0]      va,
    input  logic             is32,
    input  logic [2:0]       lvl,
    input  logic [PA_W-13:0] base,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-13:0] lvl_mask,
    output logic [PA_W-13:0] vpn
);
    localparam int PPN_W = PA_W - PG_OFS;

    int          shift;
    logic [63:0] src;
    logic [63:0] sh;
    logic [9:0]  idx;

    always_comb begin
        shift = (is32 ? IDX_W_NARROW : IDX_W_WIDE) * int'(lvl);
        src   = is32 ? {32'd0, va[31:0]} : va;
        sh    = src >> (PG_OFS + shift);
        idx   = is32 ? sh[9:0] : {1'b0, sh[8:0]};
        entry_addr = {base, {PG_OFS{1'b0}}}
                   + (is32 ? (PA_W'(idx) << 2) : (PA_W'(idx) << 3));
        lvl_mask = (PPN_W'(1) << shift) - PPN_W'(1);
        vpn      = is32 ? PPN_W'(va[31:12]) : va[PG_OFS +: PPN_W];
    end
endmodule

// File: rtl/ptw_leaf_chk.sv
module ptw_leaf_chk
    import ptw_pkg::*;
#(
    parameter int PPN_W = 44
) (
    input  pte_flags_t       f,
    input  acc_e             acc,
    input  logic [1:0]       prv,
    input  logic             sum,
    input  logic             mxr,
    input  logic [PPN_W-1:0] ppn,
    input  logic [PPN_W-1:0] lvl_mask,
    output logic             fault,
    output logic             pr,
    output logic             pw,
    output logic             px
);
    logic rsvd, u_bad, s_bad, misal, a_bad;

    always_comb begin
        rsvd  = f.w && !f.r;
        u_bad = f.u && (prv != PRV_USR) && (!sum || acc == ACC_FETCH);
        s_bad = !f.u && (prv != PRV_SUP);
        misal = |(ppn & lvl_mask);
        a_bad = ((acc == ACC_LOAD)  && !(f.r || (f.x && mxr)))
             || ((acc == ACC_STORE) && !f.w)
             || ((acc == ACC_FETCH) && !f.x);
        fault = rsvd || u_bad || s_bad || misal || a_bad;
        pr    = f.r || (f.x && mxr);
        pw    = f.w && ((acc == ACC_STORE) || f.d);
        px    = f.x;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_priv,
    input  logic             req_mprv,
    input  logic [1:0]       req_mpp,
    input  logic             req_sum,
    input  logic             req_mxr,
    input  logic [3:0]       req_mode,
    input  logic [PA_W-13:0] req_root,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic             mem_word4,
    input  logic             mem_rd_valid,
    input  logic [63:0]      mem_rd_data,
    input  logic             mem_rd_err,
    output logic             mem_wr_en,
    output logic [63:0]      mem_wr_data,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic [PA_W-1:0]  res_paddr,
    output logic             res_r,
    output logic             res_w,
    output logic             res_x
);
    localparam int PPN_W = PA_W - PG_OFS;

    walk_st_e         st;
    logic [63:0]      va_q;
    acc_e             acc_q;
    logic [1:0]       prv_q;
    logic             sum_q, mxr_q, is32_q;
    logic [2:0]       lvl_q;
    logic [PPN_W-1:0] base_q;
    logic [63:0]      wdata_q;
    stat_e            stat_q;
    logic [PA_W-1:0]  pa_q;
    logic             r_q, w_q, x_q;

    // request decode
    logic [1:0] eprv_c;
    logic [2:0] depth_c;
    acc_e       acc_c;
    always_comb begin
        acc_c   = acc_e'(req_acc);
        eprv_c  = (req_priv == PRV_MCH && acc_c != ACC_FETCH && req_mprv)
                ? req_mpp : req_priv;
        depth_c = depth_of(req_mode);
    end

    // entry decode
    logic [63:0]      pte_c;
    pte_flags_t       fl_c;
    logic [PPN_W-1:0] ppn_c, lmask_c, vpn_c;
    logic [63:0]      upd_c;
    logic             lf_fault, lf_r, lf_w, lf_x;

    always_comb begin
        pte_c = is32_q ? {32'd0, mem_rd_data[31:0]} : mem_rd_data;
        fl_c  = pte_flags_t'(pte_c[7:0]);
        ppn_c = is32_q ? PPN_W'(pte_c[31:PTE_PPN_LSB])
                       : pte_c[PTE_PPN_LSB +: PPN_W];
        upd_c = pte_c | 64'h40 | ((acc_q == ACC_STORE) ? 64'h80 : 64'h0);
    end

    ptw_addr_gen #(.PA_W(PA_W)) u_agen (
        .va         (va_q),
        .is32       (is32_q),
        .lvl        (lvl_q),
        .base       (base_q),
        .entry_addr (mem_addr),
        .lvl_mask   (lmask_c),
        .vpn        (vpn_c)
    );

    ptw_leaf_chk #(.PPN_W(PPN_W)) u_leaf (
        .f        (fl_c),
        .acc      (acc_q),
        .prv      (prv_q),
        .sum      (sum_q),
        .mxr      (mxr_q),
        .ppn      (ppn_c),
        .lvl_mask (lmask_c),
        .fault    (lf_fault),
        .pr       (lf_r),
        .pw       (lf_w),
        .px       (lf_x)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            va_q    <= '0;
            acc_q   <= ACC_LOAD;
            prv_q   <= '0;
            sum_q   <= 1'b0;
            mxr_q   <= 1'b0;
            is32_q  <= 1'b0;
            lvl_q   <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            stat_q  <= ST_OK;
            pa_q    <= '0;
            r_q     <= 1'b0;
            w_q     <= 1'b0;
            x_q     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= acc_c;
                    prv_q  <= eprv_c;
                    sum_q  <= req_sum;
                    mxr_q  <= req_mxr;
                    is32_q <= (req_mode == MD_L2);
                    base_q <= req_root;
                    lvl_q  <= depth_c - 3'd1;
                    if (eprv_c == PRV_MCH || req_mode == MD_BARE) begin
                        st     <= S_DONE;
                        stat_q <= ST_OK;
                        pa_q   <= req_vaddr[PA_W-1:0];
                        {r_q, w_q, x_q} <= 3'b111;
                    end else if (depth_c == 3'd0 ||
                                 (req_mode != MD_L2 && !canon_ok(req_vaddr, depth_c))) begin
                        st     <= S_DONE;
                        stat_q <= ST_PAGE;
                        pa_q   <= '0;
                        {r_q, w_q, x_q} <= 3'b000;
                    end else begin
                        st <= S_REQ;
                    end
                end
                S_REQ: st <= S_WAIT;
                S_WAIT: if (mem_rd_valid) begin
                    if (mem_rd_err) begin
                        st     <= S_DONE;
                        stat_q <= ST_ACCESS;
                        pa_q   <= '0;
                        {r_q, w_q, x_q} <= 3'b000;
                    end else if (fl_c.v && !fl_c.r && !fl_c.w && !fl_c.x && lvl_q != 3'd0) begin
                        lvl_q  <= lvl_q - 3'd1;
                        base_q <= ppn_c;
                        st     <= S_REQ;
                    end else if (!fl_c.v || (!fl_c.r && !fl_c.w && !fl_c.x) || lf_fault) begin
                        st     <= S_DONE;
                        stat_q <= ST_PAGE;
                        pa_q   <= '0;
                        {r_q, w_q, x_q} <= 3'b000;
                    end else begin
                        stat_q  <= ST_OK;
                        pa_q    <= {(ppn_c | (vpn_c & lmask_c)), va_q[PG_OFS-1:0]};
                        {r_q, w_q, x_q} <= {lf_r, lf_w, lf_x};
                        wdata_q <= upd_c;
                        st      <= (upd_c != pte_c) ? S_WB : S_DONE;
                    end
                end
                S_WB:    st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready   = (st == S_IDLE);
    assign mem_rd_req  = (st == S_REQ);
    assign mem_wr_en   = (st == S_WB);
    assign mem_word4   = is32_q;
    assign mem_wr_data = wdata_q;
    assign res_valid   = (st == S_DONE);
    assign res_status  = stat_q;
    assign res_paddr   = pa_q;
    assign res_r       = r_q;
    assign res_w       = w_q;
    assign res_x       = x_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 56
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [63:0]     req_vaddr,
    input logic [3:0]      req_mode,
    input logic            mem_rd_req,
    input logic            mem_rd_valid,
    input logic            mem_rd_err,
    input logic            mem_wr_en,
    input logic            res_valid,
    input logic [1:0]      res_status,
    input logic [PA_W-1:0] res_paddr,
    input logic            res_r,
    input logic            res_w,
    input logic            res_x
);
    p_bare_pass_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mode == 4'd0 |=>
            res_valid && res_status == 2'd0 &&
            res_paddr == $past(req_vaddr[PA_W-1:0]) && res_r && res_w && res_x);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_req && !mem_wr_en && !res_valid);

    p_wb_then_done_r10: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> res_valid && res_status == 2'd0);

    p_fault_no_wb_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_status != 2'd0 |-> !$past(mem_wr_en));

    p_fault_no_perm_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_status != 2'd0 |-> !res_r && !res_w && !res_x);

    p_err_access_r13: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && mem_rd_err && !req_ready |=>
            res_valid && res_status == 2'd2);

    p_result_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid && req_ready);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_mode     (req_mode),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_err   (mem_rd_err),
    .mem_wr_en    (mem_wr_en),
    .res_valid    (res_valid),
    .res_status   (res_status),
    .res_paddr    (res_paddr),
    .res_r        (res_r),
    .res_w        (res_w),
    .res_x        (res_x)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int PA_W = 56;

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_vaddr = '0;
    logic [1:0]      req_acc = '0, req_priv = '0, req_mpp = '0;
    logic            req_mprv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
    logic [3:0]      req_mode = '0;
    logic [PA_W-13:0] req_root = '0;
    logic            mem_rd_req, mem_word4, mem_wr_en;
    logic [PA_W-1:0] mem_addr;
    logic            mem_rd_valid = 1'b0, mem_rd_err = 1'b0;
    logic [63:0]     mem_rd_data = '0, mem_wr_data;
    logic            res_valid, res_r, res_w, res_x;
    logic [1:0]      res_status;
    logic [PA_W-1:0] res_paddr;

    always #10 clk = ~clk;

    ptw_walker #(.PA_W(PA_W)) dut (.*);

    // memory model
    logic [63:0] mem [logic [55:0]];
    logic [55:0] err_addr = '1;
    int rd_cnt = 0, wr_cnt = 0;

    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_req;
        if (mem_rd_req) begin
            mem_rd_data <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
            mem_rd_err  <= (mem_addr == err_addr);
            rd_cnt = rd_cnt + 1;
        end else begin
            mem_rd_err <= 1'b0;
        end
        if (mem_wr_en) begin
            mem[mem_addr] = mem_word4 ? {32'd0, mem_wr_data[31:0]} : mem_wr_data;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [63:0] mkpte(logic [43:0] ppn, logic [7:0] fl);
        return ({20'd0, ppn} << 10) | {56'd0, fl};
    endfunction

    // scoreboard
    typedef struct {
        string           tag;
        logic [1:0]      st;
        logic [PA_W-1:0] pa;
        logic [2:0]      rwx;
        int              rd, wr, rd0, wr0;
    } exp_t;
    exp_t sb[$];
    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check("R12", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "status", res_status, e.st);
                check(e.tag, "rwx", {res_r, res_w, res_x}, e.rwx);
                if (e.st == 2'd0) check(e.tag, "paddr", res_paddr, e.pa);
                if (e.rd >= 0) check(e.tag, "reads", rd_cnt - e.rd0, e.rd);
                check(e.tag, "writes", wr_cnt - e.wr0, e.wr);
            end
        end
    end

    task automatic run(string tag, logic [63:0] va, logic [1:0] acc, logic [1:0] prv,
                       logic mprv, logic [1:0] mpp, logic sum, logic mxr,
                       logic [3:0] mode, logic [43:0] root, logic [1:0] est,
                       logic [55:0] epa, logic [2:0] erwx, int erd, int ewr);
        exp_t e;
        @(negedge clk);
        e.tag = tag; e.st = est; e.pa = epa; e.rwx = erwx; e.rd = erd; e.wr = ewr;
        e.rd0 = rd_cnt; e.wr0 = wr_cnt;
        sb.push_back(e);
        req_vaddr = va; req_acc = acc; req_priv = prv; req_mprv = mprv; req_mpp = mpp;
        req_sum = sum; req_mxr = mxr; req_mode = mode; req_root = root;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic chk_mem(string tag, logic [55:0] a, logic [63:0] exp);
        check(tag, "entry", mem.exists(a) ? mem[a] : 64'd0, exp);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [1:0] LD = 0, STO = 1, FE = 2, U = 0, S = 1, M = 3;

    initial begin
        // three-level tables, root page 0x100
        mem[56'h100008] = mkpte(44'h200, FV);
        mem[56'h100808] = mkpte(44'h200, FV);
        mem[56'h200008] = mkpte(44'h300, FV);
        mem[56'h200010] = mkpte(44'h400, FV | FR | FX | FA);
        mem[56'h200018] = mkpte(44'h401, FV | FR | FA);
        mem[56'h300018] = mkpte(44'h12345, FV | FR | FW | FA | FD);
        mem[56'h300020] = mkpte(44'h12346, FV | FR | FW);
        mem[56'h300028] = mkpte(44'h12347, FV | FR | FW);
        mem[56'h300030] = mkpte(44'h1, FV | FW);
        mem[56'h300038] = mkpte(44'h1, FV | FW | FX);
        mem[56'h300048] = mkpte(44'h500, FV);
        mem[56'h300050] = mkpte(44'h600, FV | FR | FW | FX | FU | FA | FD);
        mem[56'h300058] = mkpte(44'h700, FV | FX | FA);
        mem[56'h300060] = mkpte(44'h701, FV | FR | FA | FD);
        // two-level tables, root page 0x80, 4-byte entries
        mem[56'h80004] = mkpte(44'h90, FV);
        mem[56'h80008] = mkpte(44'h400, FV | FR | FA);
        mem[56'h9000C] = mkpte(44'hABCDE, FV | FR | FW | FA);
        // four-level, root 0x1000
        mem[56'h1000008] = mkpte(44'h1001, FV);
        mem[56'h1001000] = mkpte(44'h1002, FV);
        mem[56'h1002000] = mkpte(44'h1003, FV);
        mem[56'h1003008] = mkpte(44'h5555, FV | FR | FA);
        // five-level, root 0x2000
        mem[56'h2000008] = mkpte(44'h2001, FV);
        mem[56'h2001000] = mkpte(44'h2002, FV);
        mem[56'h2002000] = mkpte(44'h2003, FV);
        mem[56'h2003000] = mkpte(44'h2004, FV);
        mem[56'h2004010] = mkpte(44'h6666, FV | FR | FW | FX | FA | FD);

        repeat (3) @(negedge clk);
        check("R12", "reset ready", req_ready, 1);
        check("R12", "reset res_valid", res_valid, 0);
        check("R3", "reset rd_req", mem_rd_req, 0);
        rst = 1'b0;

        // R1 bypass
        run("R1 bare", 64'h0123_4567_89AB, LD, S, 0, 0, 0, 0, 4'd0, 44'h100, 0, 56'h0123_4567_89AB, 3'b111, 0, 0);
        run("R1 machine noncanon", 64'hDEAD_0000_0000_1000, FE, M, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'hAD_0000_0000_1000, 3'b111, 0, 0);
        // R3 R11 R12 three-level 4 KiB leaf
        run("R3 l3 load", 64'h4020_3456, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h1234_5456, 3'b110, 3, 0);
        // R10 write-back
        run("R10 store sets D", 64'h4020_4456, STO, S, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h1234_6456, 3'b110, 3, 1);
        chk_mem("R10", 56'h300020, mkpte(44'h12346, FV | FR | FW | FA | FD));
        run("R10 load sets A", 64'h4020_5000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h1234_7000, 3'b100, 3, 1);
        chk_mem("R10", 56'h300028, mkpte(44'h12347, FV | FR | FW | FA));
        // R11 superpage
        run("R11 2M fetch", 64'h4041_2345, FE, S, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h41_2345, 3'b101, 2, 0);
        // R8 misaligned
        run("R8 misaligned", 64'h4060_0000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 2, 0);
        // R6 reserved
        run("R6 w only", 64'h4020_6000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R6 w+x", 64'h4020_7000, STO, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        // R5 invalid and last-level pointer
        run("R5 V clear", 64'h4020_8000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R5 last pointer", 64'h4020_9000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        // R7 user/supervisor
        run("R7 S user no SUM", 64'h4020_A010, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R7 S user SUM", 64'h4020_A010, LD, S, 0, 0, 1, 0, 4'd8, 44'h100, 0, 56'h60_0010, 3'b111, 3, 0);
        run("R7 S fetch user", 64'h4020_A010, FE, S, 0, 0, 1, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R7 U user", 64'h4020_A010, LD, U, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h60_0010, 3'b111, 3, 0);
        run("R7 U sup page", 64'h4020_3456, LD, U, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        // R2 modify-privilege
        run("R2 mprv user", 64'h4020_3456, LD, M, 1, U, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R2 mprv sup", 64'h4020_3456, LD, M, 1, S, 0, 0, 4'd8, 44'h100, 0, 56'h1234_5456, 3'b110, 3, 0);
        run("R2 mprv fetch", 64'h4020_3456, FE, M, 1, U, 0, 0, 4'd8, 44'h100, 0, 56'h4020_3456, 3'b111, 0, 0);
        // R9 access rules
        run("R9 x-only no MXR", 64'h4020_B000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R9 x-only MXR", 64'h4020_B000, LD, S, 0, 0, 0, 1, 4'd8, 44'h100, 0, 56'h70_0000, 3'b101, 3, 0);
        run("R9 store r-only", 64'h4020_C000, STO, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        run("R9 fetch no X", 64'h4020_3456, FE, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 3, 0);
        // R4 high bits
        run("R4 noncanon", 64'h0000_0080_0000_0000, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 1, 0, 3'b000, 0, 0);
        run("R4 negative ok", 64'hFFFF_FFC0_4020_3456, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 0, 56'h1234_5456, 3'b110, 3, 0);
        run("R4 bad scheme", 64'h4020_3456, LD, S, 0, 0, 0, 0, 4'd5, 44'h100, 1, 0, 3'b000, 0, 0);
        // R3 two-level, four-level, five-level
        run("R3 l2 store", 64'h0040_3ABC, STO, S, 0, 0, 0, 0, 4'd1, 44'h80, 0, 56'hABCD_EABC, 3'b110, 2, 1);
        chk_mem("R3", 56'h9000C, mkpte(44'hABCDE, FV | FR | FW | FA | FD));
        run("R11 l2 4M", 64'h0080_1234, LD, S, 0, 0, 0, 0, 4'd1, 44'h80, 0, 56'h40_1234, 3'b100, 1, 0);
        run("R3 l4 load", 64'h0000_0080_0000_1008, LD, S, 0, 0, 0, 0, 4'd9, 44'h1000, 0, 56'h555_5008, 3'b100, 4, 0);
        run("R3 l5 fetch", 64'h0001_0000_0000_2000, FE, S, 0, 0, 0, 0, 4'd10, 44'h2000, 0, 56'h666_6000, 3'b111, 5, 0);
        // R13 read error with valid pointer data in the same response
        err_addr = 56'h200008;
        run("R13 read error", 64'h4020_3456, LD, S, 0, 0, 0, 0, 4'd8, 44'h100, 2, 0, 3'b000, 2, 0);
        err_addr = '1;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule